// File: doc/BRIEF.md
# NAND ECC Chunk Read Sequencer

This block drives the read of one NAND page so that a hardware BCH engine sees every data chunk (512 bytes by default) followed at once by the 13 check bytes that belong to it. For each chunk it asks an external NAND bus master for a column-addressed data read. It then pulses the engine's enable and counts the data bytes as they stream past. After that it asks for one or more spare-area reads at the offsets where that chunk's check bytes are stored. The check bytes are gathered into a 13-byte buffer, and the block waits for the engine's code-ready status before it reports the chunk as done.

Two spare layouts are built in, and the chunk count selects between them. With more than one chunk, chunk n's check bytes form one 13-byte run at spare offset 2 + 16·n; spare bytes 0 and 1 stay untouched because they hold the bad-block marker. With a single chunk (small-page device), the bytes come in two pieces: 4 bytes at spare offset 0, then 9 bytes at spare offset 6. On a 16-bit device every spare length is rounded up to an even number, and any byte beyond the thirteenth is dropped.

Requests use a valid/ready handshake. Read bytes arrive one per cycle on a valid-qualified byte stream. The ECC arithmetic and the NAND bus timing live outside this block.

Top module: `nand_ecc_chunk_seq`

## Requirements
- R1: After reset, and again after a page completes, reqValid, eccEnable, chunkDone and pageDone are all low, and no request appears until startPage is seen high.
- R2: Chunks are handled in ascending order from 0. The data request for chunk n has reqSpare=0, reqCol=n*CHUNK_BYTES and reqLen=CHUNK_BYTES, and reqPage carries the page address latched at start.
- R3: eccEnable is a one-cycle pulse in the cycle right after a data request is accepted, and it comes before any spare request of that chunk.
- R4: With NUM_CHUNKS>1, once CHUNK_BYTES data bytes have arrived the block issues exactly one spare request for chunk n, with reqSpare=1, reqCol=2+16*n, and reqLen=13 (14 when BUS16=1).
- R5: With NUM_CHUNKS=1, the block issues two spare requests in this order: reqCol=0 with reqLen=4, then reqCol=6 with reqLen=9 (10 when BUS16=1).
- R6: When chunkDone is high, eccBytes holds the first 13 spare bytes received for that chunk, in arrival order, with byte k at bits [8k+7:8k]. Spare bytes after the thirteenth are dropped.
- R7: After the last spare byte, no chunkDone and no new request appear until eccCodeReady is sampled high. chunkDone then pulses for one cycle, in the cycle after, with chunkIdx=n.
- R8: pageDone pulses together with the chunkDone of the last chunk, and at no other time.
- R9: A startPage pulse while a page is in progress has no effect: reqPage and the chunk order stay as they were.
- R10: Bytes that arrive with rdValid high while the block waits for eccCodeReady are neither counted nor captured into eccBytes.
- R11: While reqValid is high and reqReady is low, reqSpare, reqCol and reqLen hold steady and reqValid stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startPage | input | 1 | Begin reading one page (accepted only when idle) |
| pageAddr | input | PAGE_W | Page address, latched at start |
| reqValid | output | 1 | Read request to the bus master is valid |
| reqReady | input | 1 | Bus master accepts the request |
| reqSpare | output | 1 | 0 = data-area read, 1 = spare-area read |
| reqCol | output | COL_W | Column: data byte offset, or spare byte offset |
| reqLen | output | LEN_W | Number of bytes to fetch |
| reqPage | output | PAGE_W | Latched page address |
| rdValid | input | 1 | A read byte is present on rdByte |
| rdByte | input | 8 | Read byte from the bus master |
| eccEnable | output | 1 | One-cycle enable pulse for the ECC engine |
| eccCodeReady | input | 1 | ECC engine has finished the chunk |
| chunkDone | output | 1 | One-cycle pulse: chunk fully read and checked |
| chunkIdx | output | CHK_W | Index of the chunk reported by chunkDone |
| pageDone | output | 1 | One-cycle pulse with the final chunkDone |
| eccBytes | output | ECC_BYTES*8 | Gathered check bytes, byte k at [8k+7:8k] |

## Verification
The hardest case to reach from the ports is the 16-bit small-page layout. There the second spare read fetches one byte more than the buffer keeps, and that surplus byte must be dropped rather than overwrite a stored one. The bench places a second instance configured with one chunk and a 16-bit bus next to the default one and steers shared stimulus to it. It also drives stray bytes while the block waits for code-ready, and holds reqReady low for several cycles, which reaches the "ignored" and "held" cases without any internal access.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA_REQ,
    ST_DATA_RECV,
    ST_SPARE_REQ,
    ST_SPARE_RECV,
    ST_WAIT_CODE
  } seq_state_t;

  // strobes from control to the gather datapath
  typedef struct packed {
    logic gatherStart;  // restart the check-byte buffer for a new chunk
    logic spareByte;    // a spare byte is on rdByte this cycle
  } seq_strobe_t;

endpackage

// File: rtl/spare_layout.sv
module spare_layout #(
  parameter int NUM_CHUNKS     = 8,
  parameter int ECC_BYTES      = 13,
  parameter bit BUS16          = 1'b0,
  parameter int SPARE_BASE     = 2,
  parameter int SPARE_STRIDE   = 16,
  parameter int SMALL_HEAD_LEN = 4,
  parameter int SMALL_TAIL_OFF = 6,
  parameter int CHK_W          = 3,
  parameter int COL_W          = 13,
  parameter int LEN_W          = 10
) (
  input  logic [CHK_W-1:0] chunk,
  input  logic             piece,
  output logic [COL_W-1:0] pieceCol,
  output logic [LEN_W-1:0] pieceLen,
  output logic             pieceLast
);

  localparam bit SMALL      = (NUM_CHUNKS == 1);
  localparam bit PIECE_LAST = SMALL ? 1'b1 : 1'b0;

  logic [COL_W-1:0] chunkBase;
  logic [COL_W-1:0] pieceOff;
  logic [LEN_W-1:0] rawLen;

  assign chunkBase = COL_W'(chunk) * COL_W'(SPARE_STRIDE);
  assign pieceLast = (piece == PIECE_LAST);

  generate
    if (SMALL) begin : g_small
      // two pieces: head then tail, skipping the bytes between them
      assign pieceOff = piece ? COL_W'(SMALL_TAIL_OFF) : '0;
      assign rawLen   = piece ? LEN_W'(ECC_BYTES - SMALL_HEAD_LEN)
                              : LEN_W'(SMALL_HEAD_LEN);
    end else begin : g_large
      assign pieceOff = COL_W'(SPARE_BASE);
      assign rawLen   = LEN_W'(ECC_BYTES);
    end
  endgenerate

  assign pieceCol = chunkBase + pieceOff;

  generate
    if (BUS16) begin : g_even
      assign pieceLen = (rawLen + LEN_W'(1)) & ~LEN_W'(1);
    end else begin : g_byte
      assign pieceLen = rawLen;
    end
  endgenerate

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int NUM_CHUNKS  = 8,
  parameter int CHUNK_BYTES = 512,
  parameter int PAGE_W      = 16,
  parameter int CHK_W       = 3,
  parameter int COL_W       = 13,
  parameter int LEN_W       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startPage,
  input  logic [PAGE_W-1:0] pageAddr,
  input  logic              reqReady,
  input  logic              rdValid,
  input  logic              eccCodeReady,
  input  logic [COL_W-1:0]  pieceCol,
  input  logic [LEN_W-1:0]  pieceLen,
  input  logic              pieceLast,
  output logic [CHK_W-1:0]  chunkCnt,
  output logic              pieceIdx,
  output seq_strobe_t       strobe,
  output logic              reqValid,
  output logic              reqSpare,
  output logic [COL_W-1:0]  reqCol,
  output logic [LEN_W-1:0]  reqLen,
  output logic [PAGE_W-1:0] reqPage,
  output logic              eccEnable,
  output logic              chunkDone,
  output logic [CHK_W-1:0]  chunkIdx,
  output logic              pageDone
);

  localparam logic [LEN_W-1:0] LAST_DATA  = LEN_W'(CHUNK_BYTES - 1);
  localparam logic [CHK_W-1:0] LAST_CHUNK = CHK_W'(NUM_CHUNKS - 1);

  seq_state_t       state;
  logic [LEN_W-1:0] byteCnt;
  logic             dataLast;
  logic             spareLast;

  assign dataLast  = (byteCnt == LAST_DATA);
  assign spareLast = (byteCnt == pieceLen - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      chunkCnt  <= '0;
      pieceIdx  <= 1'b0;
      byteCnt   <= '0;
      reqPage   <= '0;
      eccEnable <= 1'b0;
      chunkDone <= 1'b0;
      chunkIdx  <= '0;
      pageDone  <= 1'b0;
    end else begin
      eccEnable <= 1'b0;
      chunkDone <= 1'b0;
      pageDone  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startPage) begin
            reqPage  <= pageAddr;
            chunkCnt <= '0;
            state    <= ST_DATA_REQ;
          end
        end
        ST_DATA_REQ: begin
          if (reqReady) begin
            eccEnable <= 1'b1;
            byteCnt   <= '0;
            state     <= ST_DATA_RECV;
          end
        end
        ST_DATA_RECV: begin
          if (rdValid) begin
            if (dataLast) begin
              byteCnt  <= '0;
              pieceIdx <= 1'b0;
              state    <= ST_SPARE_REQ;
            end else begin
              byteCnt <= byteCnt + LEN_W'(1);
            end
          end
        end
        ST_SPARE_REQ: begin
          if (reqReady) begin
            byteCnt <= '0;
            state   <= ST_SPARE_RECV;
          end
        end
        ST_SPARE_RECV: begin
          if (rdValid) begin
            if (spareLast) begin
              byteCnt <= '0;
              if (pieceLast) begin
                state <= ST_WAIT_CODE;
              end else begin
                pieceIdx <= 1'b1;
                state    <= ST_SPARE_REQ;
              end
            end else begin
              byteCnt <= byteCnt + LEN_W'(1);
            end
          end
        end
        ST_WAIT_CODE: begin
          if (eccCodeReady) begin
            chunkDone <= 1'b1;
            chunkIdx  <= chunkCnt;
            if (chunkCnt == LAST_CHUNK) begin
              pageDone <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              chunkCnt <= chunkCnt + CHK_W'(1);
              state    <= ST_DATA_REQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.gatherStart = (state == ST_DATA_RECV) && rdValid && dataLast;
    strobe.spareByte   = (state == ST_SPARE_RECV) && rdValid;
  end

  assign reqValid = (state == ST_DATA_REQ) || (state == ST_SPARE_REQ);
  assign reqSpare = (state == ST_SPARE_REQ);
  assign reqCol   = reqSpare ? pieceCol
                             : COL_W'(chunkCnt) * COL_W'(CHUNK_BYTES);
  assign reqLen   = reqSpare ? pieceLen : LEN_W'(CHUNK_BYTES);

endmodule

// File: rtl/ecc_gather.sv
module ecc_gather
  import nand_seq_pkg::*;
#(
  parameter int ECC_BYTES = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  seq_strobe_t            strobe,
  input  logic [7:0]             rdByte,
  output logic [ECC_BYTES*8-1:0] eccBytes
);

  localparam int KEEP_W = $clog2(ECC_BYTES + 1);

  logic [KEEP_W-1:0] keepCnt;
  logic              keepOpen;

  assign keepOpen = (keepCnt < KEEP_W'(ECC_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keepCnt <= '0;
    end else if (strobe.gatherStart) begin
      keepCnt <= '0;
    end else if (strobe.spareByte && keepOpen) begin
      keepCnt <= keepCnt + KEEP_W'(1);
    end
  end

  for (genvar i = 0; i < ECC_BYTES; i++) begin : g_slot
    logic [7:0] slot;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot <= '0;
      end else if (strobe.spareByte && keepOpen && keepCnt == KEEP_W'(i)) begin
        slot <= rdByte;
      end
    end
    assign eccBytes[8*i +: 8] = slot;
  end

endmodule

// File: rtl/nand_ecc_chunk_seq.sv
module nand_ecc_chunk_seq
  import nand_seq_pkg::*;
#(
  parameter int  NUM_CHUNKS     = 8,
  parameter int  CHUNK_BYTES    = 512,
  parameter int  ECC_BYTES      = 13,
  parameter bit  BUS16          = 1'b0,
  parameter int  SPARE_BASE     = 2,
  parameter int  SPARE_STRIDE   = 16,
  parameter int  SMALL_HEAD_LEN = 4,
  parameter int  SMALL_TAIL_OFF = 6,
  parameter int  PAGE_W         = 16,
  localparam int CHK_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
  localparam int COL_W = $clog2(NUM_CHUNKS * CHUNK_BYTES + 1),
  localparam int LEN_W = $clog2(CHUNK_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   startPage,
  input  logic [PAGE_W-1:0]      pageAddr,
  output logic                   reqValid,
  input  logic                   reqReady,
  output logic                   reqSpare,
  output logic [COL_W-1:0]       reqCol,
  output logic [LEN_W-1:0]       reqLen,
  output logic [PAGE_W-1:0]      reqPage,
  input  logic                   rdValid,
  input  logic [7:0]             rdByte,
  output logic                   eccEnable,
  input  logic                   eccCodeReady,
  output logic                   chunkDone,
  output logic [CHK_W-1:0]       chunkIdx,
  output logic                   pageDone,
  output logic [ECC_BYTES*8-1:0] eccBytes
);

  seq_strobe_t      strobe;
  logic [CHK_W-1:0] chunkCnt;
  logic             pieceIdx;
  logic [COL_W-1:0] pieceCol;
  logic [LEN_W-1:0] pieceLen;
  logic             pieceLast;

  spare_layout #(
    .NUM_CHUNKS(NUM_CHUNKS), .ECC_BYTES(ECC_BYTES), .BUS16(BUS16),
    .SPARE_BASE(SPARE_BASE), .SPARE_STRIDE(SPARE_STRIDE),
    .SMALL_HEAD_LEN(SMALL_HEAD_LEN), .SMALL_TAIL_OFF(SMALL_TAIL_OFF),
    .CHK_W(CHK_W), .COL_W(COL_W), .LEN_W(LEN_W)
  ) u_layout (
    .chunk(chunkCnt), .piece(pieceIdx),
    .pieceCol(pieceCol), .pieceLen(pieceLen), .pieceLast(pieceLast)
  );

  seq_ctrl #(
    .NUM_CHUNKS(NUM_CHUNKS), .CHUNK_BYTES(CHUNK_BYTES), .PAGE_W(PAGE_W),
    .CHK_W(CHK_W), .COL_W(COL_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startPage(startPage), .pageAddr(pageAddr),
    .reqReady(reqReady), .rdValid(rdValid), .eccCodeReady(eccCodeReady),
    .pieceCol(pieceCol), .pieceLen(pieceLen), .pieceLast(pieceLast),
    .chunkCnt(chunkCnt), .pieceIdx(pieceIdx), .strobe(strobe),
    .reqValid(reqValid), .reqSpare(reqSpare), .reqCol(reqCol),
    .reqLen(reqLen), .reqPage(reqPage), .eccEnable(eccEnable),
    .chunkDone(chunkDone), .chunkIdx(chunkIdx), .pageDone(pageDone)
  );

  ecc_gather #(
    .ECC_BYTES(ECC_BYTES)
  ) u_gather (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdByte(rdByte),
    .eccBytes(eccBytes)
  );

endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker #(
  parameter int CHUNK_BYTES = 512,
  parameter int COL_W       = 13,
  parameter int LEN_W       = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqReady,
  input logic             reqSpare,
  input logic [COL_W-1:0] reqCol,
  input logic [LEN_W-1:0] reqLen,
  input logic             eccEnable,
  input logic             eccCodeReady,
  input logic             chunkDone,
  input logic             pageDone
);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqSpare) &&
                                 $stable(reqCol) && $stable(reqLen)));

  assert_data_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqSpare) |-> ((reqLen == LEN_W'(CHUNK_BYTES)) &&
                                 ((int'(reqCol) % CHUNK_BYTES) == 0)));

  assert_enable_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eccEnable |-> $past(reqValid && reqReady && !reqSpare));

  assert_enable_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eccEnable |=> !eccEnable);

  assert_done_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chunkDone |-> $past(eccCodeReady));

  assert_page_with_chunk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pageDone |-> chunkDone);

endmodule

bind nand_ecc_chunk_seq nand_seq_checker #(
  .CHUNK_BYTES(CHUNK_BYTES), .COL_W(COL_W), .LEN_W(LEN_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
  .reqSpare(reqSpare), .reqCol(reqCol), .reqLen(reqLen),
  .eccEnable(eccEnable), .eccCodeReady(eccCodeReady),
  .chunkDone(chunkDone), .pageDone(pageDone)
);

// File: tb/tb_nand_ecc_chunk_seq.sv
`timescale 1ns/1ps
module tb_nand_ecc_chunk_seq;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        startPage = 1'b0;
  logic [15:0] pageAddr = '0;
  logic        reqReady = 1'b0;
  logic        rdValid = 1'b0;
  logic [7:0]  rdByte = '0;
  logic        eccCodeReady = 1'b0;
  logic        sel = 1'b0;  // 0: default instance, 1: small 16-bit instance

  // default instance: 8 chunks, 8-bit bus
  logic         aReqValid, aReqSpare, aEccEn, aDone, aPageDone;
  logic [12:0]  aReqCol;
  logic [9:0]   aReqLen;
  logic [15:0]  aReqPage;
  logic [2:0]   aIdx;
  logic [103:0] aEcc;

  // small-page instance: 1 chunk, 16-bit bus
  logic         bReqValid, bReqSpare, bEccEn, bDone, bPageDone;
  logic [9:0]   bReqCol;
  logic [9:0]   bReqLen;
  logic [15:0]  bReqPage;
  logic [0:0]   bIdx;
  logic [103:0] bEcc;

  nand_ecc_chunk_seq dut (
    .clk(clk), .rst_n(rst_n), .startPage(startPage && !sel), .pageAddr(pageAddr),
    .reqValid(aReqValid), .reqReady(reqReady && !sel), .reqSpare(aReqSpare),
    .reqCol(aReqCol), .reqLen(aReqLen), .reqPage(aReqPage),
    .rdValid(rdValid), .rdByte(rdByte), .eccEnable(aEccEn),
    .eccCodeReady(eccCodeReady), .chunkDone(aDone), .chunkIdx(aIdx),
    .pageDone(aPageDone), .eccBytes(aEcc)
  );

  nand_ecc_chunk_seq #(.NUM_CHUNKS(1), .BUS16(1'b1)) dutSmall (
    .clk(clk), .rst_n(rst_n), .startPage(startPage && sel), .pageAddr(pageAddr),
    .reqValid(bReqValid), .reqReady(reqReady && sel), .reqSpare(bReqSpare),
    .reqCol(bReqCol), .reqLen(bReqLen), .reqPage(bReqPage),
    .rdValid(rdValid), .rdByte(rdByte), .eccEnable(bEccEn),
    .eccCodeReady(eccCodeReady), .chunkDone(bDone), .chunkIdx(bIdx),
    .pageDone(bPageDone), .eccBytes(bEcc)
  );

  // view of the selected instance
  logic         vReqValid, vReqSpare, vEccEn, vDone, vPageDone;
  int           vReqCol, vReqLen, vReqPage, vIdx;
  logic [103:0] vEcc;
  always_comb begin
    vReqValid = sel ? bReqValid : aReqValid;
    vReqSpare = sel ? bReqSpare : aReqSpare;
    vEccEn    = sel ? bEccEn    : aEccEn;
    vDone     = sel ? bDone     : aDone;
    vPageDone = sel ? bPageDone : aPageDone;
    vReqCol   = sel ? int'(bReqCol)  : int'(aReqCol);
    vReqLen   = sel ? int'(bReqLen)  : int'(aReqLen);
    vReqPage  = sel ? int'(bReqPage) : int'(aReqPage);
    vIdx      = sel ? int'(bIdx)     : int'(aIdx);
    vEcc      = sel ? bEcc : aEcc;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] spareVal(input int c, input int k);
    return 8'(8'h3C + c * 29 + k * 11);
  endfunction

  // wait for a request, check it, optionally hold ready low, then accept
  task automatic serveReq(input bit spare, input int col, input int len,
                          input int page, input int lag, input string req);
    @(negedge clk);
    while (!vReqValid) @(negedge clk);
    chk(vReqSpare == spare, req, "reqSpare", vReqSpare, spare);
    chk(vReqCol == col, req, "reqCol", vReqCol, col);
    chk(vReqLen == len, req, "reqLen", vReqLen, len);
    if (!spare) chk(vReqPage == page, "R2", "reqPage", vReqPage, page);
    for (int i = 0; i < lag; i++) @(negedge clk);
    if (lag > 0) begin
      chk(vReqValid && vReqCol == col && vReqLen == len && vReqSpare == spare,
          "R11", "held request column", vReqCol, col);
    end
    reqReady = 1'b1;
    @(negedge clk);
    reqReady = 1'b0;
  endtask

  task automatic sendBytes(input int n, input int c, input int base, input bit gaps);
    for (int k = 0; k < n; k++) begin
      rdValid = 1'b1;
      rdByte  = (base < 0) ? 8'(k ^ c) : spareVal(c, base + k);
      @(negedge clk);
      if (gaps && (k % 5) == 2) begin
        rdValid = 1'b0;
        @(negedge clk);
      end
    end
    rdValid = 1'b0;
  endtask

  task automatic doChunk(input int c, input int nChunks, input int page,
                         input bit gaps, input int waitCyc);
    int bad;
    serveReq(1'b0, c * 512, 512, page, gaps ? 2 : 0, "R2");
    chk(vEccEn == 1'b1, "R3", "eccEnable after data accept", vEccEn, 1);
    sendBytes(512, c, -1, gaps);
    chk(vEccEn == 1'b0, "R3", "eccEnable low after pulse", vEccEn, 0);
    if (sel) begin
      serveReq(1'b1, 0, 4, page, gaps ? 1 : 0, "R5");
      sendBytes(4, c, 0, gaps);
      serveReq(1'b1, 6, 10, page, 0, "R5");
      sendBytes(10, c, 4, gaps);   // 14 fetched, 13 kept
    end else begin
      serveReq(1'b1, 2 + 16 * c, 13, page, 0, "R4");
      sendBytes(13, c, 0, gaps);
    end
    for (int w = 0; w < waitCyc; w++) begin
      chk(!vDone && !vReqValid, "R7", "early chunkDone/request", vDone, 0);
      if (w == 0) begin
        rdValid = 1'b1;       // stray byte while waiting: R10
        rdByte  = 8'h5A;
      end
      @(negedge clk);
      rdValid = 1'b0;
    end
    eccCodeReady = 1'b1;
    @(negedge clk);
    eccCodeReady = 1'b0;
    chk(vDone == 1'b1, "R7", "chunkDone", vDone, 1);
    chk(vIdx == c, "R7", "chunkIdx", vIdx, c);
    chk(vPageDone == (c == nChunks - 1), "R8", "pageDone", vPageDone,
        (c == nChunks - 1));
    bad = 0;
    for (int k = 0; k < 13; k++)
      if (vEcc[8*k +: 8] != spareVal(c, k)) bad++;
    chk(bad == 0, "R6", "mismatched check bytes", bad, 0);
    chk(vEcc[7:0] != 8'h5A || spareVal(c, 0) == 8'h5A, "R10",
        "stray byte in slot 0", vEcc[7:0], spareVal(c, 0));
    @(negedge clk);
    chk(!vDone && !vPageDone, "R7", "chunkDone single cycle", vDone, 0);
  endtask

  task automatic runPage(input bit which, input int page, input bit gaps,
                         input int waitCyc, input bit poke);
    int nChunks;
    sel = which;
    nChunks = which ? 1 : 8;
    @(negedge clk);
    pageAddr  = 16'(page);
    startPage = 1'b1;
    @(negedge clk);
    startPage = 1'b0;
    for (int c = 0; c < nChunks; c++) begin
      if (poke && c == 2) begin
        pageAddr  = 16'hBEEF;   // R9: start while busy
        startPage = 1'b1;
        @(negedge clk);
        startPage = 1'b0;
      end
      doChunk(c, nChunks, page, gaps, waitCyc + (c % 3));
    end
    repeat (4) begin
      chk(!vReqValid && !vEccEn && !vDone, "R1", "idle after page", vReqValid, 0);
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!aReqValid && !aEccEn && !aDone && !aPageDone, "R1", "reset outputs", aReqValid, 0);
    chk(!bReqValid && !bEccEn && !bDone && !bPageDone, "R1", "reset outputs small", bReqValid, 0);
  endtask

  task automatic testLargePage();
    runPage(1'b0, 16'h1234, 1'b0, 2, 1'b1);
  endtask

  task automatic testLargeGaps();
    runPage(1'b0, 16'h0077, 1'b1, 5, 1'b0);
  endtask

  task automatic testSmallPage16();
    runPage(1'b1, 16'h4321, 1'b1, 3, 1'b0);
  endtask

  initial begin
    testReset();
    testLargePage();
    testSmallPage16();
    testLargeGaps();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule